// File: doc/BRIEF.md
# Configurable Bit-Slice Logic Cell

This block is one bit position of a row in a combinational, downward-flowing compute array. It contains no storage at all. Selectors pick two bits of the cell's column from a small bank of register bits. Four routed inputs arrive from the row above. Multiplexers steer these into a function block, and each of four routed outputs takes its value from a selector. Every routing point is a multiplexer with exactly one driver, so no configuration value can create a drive conflict.

The function block uses a 16-bit truth table in one of four modes:
- a single 4-input LUT;
- two independent 3-input LUTs;
- a ripple carry cell, where the upper half of the table yields propagate and generate and the lower half yields the sum;
- a parity cell, where the chain combines terms by exclusive-or instead of or.

Chaining the carry ports across a row of cells builds adders, subtractors, comparators and reductions.

The configuration is one 50-bit word (default parameters). Its fields, from bit 0 upward:

| Bits | Field |
|---|---|
| [11:0] | four 3-bit output selects: O1 at [2:0], O2 at [5:3], O3 at [8:6], O4 at [11:9] |
| [19:12] | two 4-bit register selects: pick0 at [15:12], pick1 at [19:16] |
| [31:20] | four 3-bit function-input selects: a at [22:20], b at [25:23], c at [28:26], d at [31:29] |
| [33:32] | mode |
| [49:34] | truth table |

In the requirements, T[n] means bit n of the truth table, and {…} lists bits with the most significant first.

Top module: `lcell_top`

## Requirements
- R1: Register select value k below 9 makes that pick equal regs_i[k]; a value of 9 or more gives 0. The two picks are chosen independently.
- R2: Each output Ok follows its own 3-bit select: codes 0..3 give in_i[0..3] (I1..I4), 4 gives f1_o, 5 gives f2_o, 6 gives pick0 and 7 gives pick1.
- R3: Each function input a, b, c, d follows its own 3-bit select: codes 0..3 give I1..I4, 4 gives pick0, 5 gives pick1, 6 gives constant 0 and 7 gives constant 1.
- R4: Mode 0 (single 4-LUT): f2_o = T[{d,c,b,a}] and f1_o = T[{1,c,b,a}].
- R5: Mode 1 (split LUTs): f1_o = T[{1,c,b,a}] and f2_o = T[{0,d,b,a}], so the two outputs depend on separate table halves.
- R6: Mode 2 (carry): p_o = T[{1,0,b,a}], g_o = T[{1,1,b,a}], carry_o = g_o | (p_o & carry_i), f2_o = T[{0,carry_i,b,a}] and f1_o = carry_o.
- R7: Mode 3 (parity): as in R6, except carry_o = g_o ^ (p_o & carry_i).
- R8: In modes 0 and 1, carry_o, p_o and g_o are 0 whatever carry_i is.
- R9: The cell holds no state. A row of 32 cells with chained carries computes, with no clock:
  - 32-bit sums from T = 16'h8696 with carry in 0;
  - differences from T = 16'h2969 with carry in 1;
  - reductions by exclusive-or in mode 3, in the final carry_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_i | input | 50 | Configuration word (field layout above) |
| regs_i | input | 9 | This column's bit of each register, regs_i[k] from register k |
| in_i | input | 4 | Routed inputs I1..I4 from the row above, in_i[0] = I1 |
| carry_i | input | 1 | Chain input from the next lower bit |
| out_o | output | 4 | Routed outputs O1..O4, out_o[0] = O1 |
| f1_o | output | 1 | First function output |
| f2_o | output | 1 | Second function output (the row result bit) |
| p_o | output | 1 | Propagate term in modes 2 and 3 |
| g_o | output | 1 | Generate term in modes 2 and 3 |
| carry_o | output | 1 | Chain output to the next higher bit |

## Verification
The bench targets the following corner cases and the failure each one exposes:

| Corner case | What a wrong design would do |
|---|---|
| Register select values past the last register | Alias back to a real register instead of reading 0 |
| Split mode | Swap the table halves, or let d leak into the left LUT |
| Carry chain with constant propagate | Show a broken ripple through all 32 bits, e.g. 0xFFFFFFFF + 1 and 0 - 1 |
| Parity mode | An or-chain returns 1 for an even population |
| Carry ports in the pure LUT modes | Pass carry_i through where it must read 0 |

// File: rtl/lcell_pkg.sv
package lcell_pkg;

   typedef enum logic [1:0] {
      FN_LUT4   = 2'd0,
      FN_SPLIT  = 2'd1,
      FN_CARRY  = 2'd2,
      FN_PARITY = 2'd3
   } fn_mode_e;

   localparam int unsigned TT_W    = 16;
   localparam int unsigned MODE_W  = 2;
   localparam int unsigned SRC_W   = 3;
   localparam int unsigned N_SRC   = 1 << SRC_W;
   localparam int unsigned N_ROUTE = 4;
   localparam int unsigned N_FIN   = 4;
   localparam int unsigned N_PICK  = 2;

   // function-input source codes
   localparam logic [SRC_W-1:0] FIN_PICK0 = 3'd4;
   localparam logic [SRC_W-1:0] FIN_PICK1 = 3'd5;
   localparam logic [SRC_W-1:0] FIN_ZERO  = 3'd6;
   localparam logic [SRC_W-1:0] FIN_ONE   = 3'd7;

   // routed-output source codes
   localparam logic [SRC_W-1:0] OUT_F1    = 3'd4;
   localparam logic [SRC_W-1:0] OUT_F2    = 3'd5;
   localparam logic [SRC_W-1:0] OUT_PICK0 = 3'd6;
   localparam logic [SRC_W-1:0] OUT_PICK1 = 3'd7;

endpackage

// File: rtl/lcell_regpick.sv
module lcell_regpick #(
   parameter int unsigned NREG  = 9,
   parameter int unsigned SEL_W = 4
) (
   input  logic [NREG-1:0]  regs_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             bit_o
);

   // out-of-range codes fall through to 0
   always_comb begin
      bit_o = 1'b0;
      for (int k = 0; k < NREG; k++) begin
         if (sel_i == SEL_W'(k)) begin
            bit_o = regs_i[k];
         end
      end
   end

endmodule

// File: rtl/lcell_mux.sv
module lcell_mux #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned N    = 1 << SEL_W
) (
   input  logic [N-1:0]     src_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             y_o
);

   assign y_o = src_i[sel_i];

endmodule

// File: rtl/lcell_func.sv
module lcell_func
   import lcell_pkg::*;
#(
   parameter bit XOR_CHAIN = 1'b1
) (
   input  logic [TT_W-1:0] tt_i,
   input  fn_mode_e        mode_i,
   input  logic            a_i,
   input  logic            b_i,
   input  logic            c_i,
   input  logic            d_i,
   input  logic            carry_i,
   output logic            f1_o,
   output logic            f2_o,
   output logic            p_o,
   output logic            g_o,
   output logic            carry_o
);

   logic pp, gg, sum, cy_or, cy_alt;
   logic left3, right3, full4;

   // table halves: upper eight bits form the left LUT
   assign left3  = tt_i[{1'b1, c_i, b_i, a_i}];
   assign right3 = tt_i[{1'b0, d_i, b_i, a_i}];
   assign full4  = tt_i[{d_i, c_i, b_i, a_i}];

   // carry use: upper half split into two 2-input tables
   assign pp    = tt_i[{2'b10, b_i, a_i}];
   assign gg    = tt_i[{2'b11, b_i, a_i}];
   assign sum   = tt_i[{1'b0, carry_i, b_i, a_i}];
   assign cy_or = gg | (pp & carry_i);

   generate
      if (XOR_CHAIN) begin : g_xor_chain
         assign cy_alt = gg ^ (pp & carry_i);
      end else begin : g_or_chain
         assign cy_alt = cy_or;
      end
   endgenerate

   always_comb begin
      f1_o    = 1'b0;
      f2_o    = 1'b0;
      p_o     = 1'b0;
      g_o     = 1'b0;
      carry_o = 1'b0;
      unique case (mode_i)
         FN_LUT4: begin
            f1_o = left3;
            f2_o = full4;
         end
         FN_SPLIT: begin
            f1_o = left3;
            f2_o = right3;
         end
         FN_CARRY: begin
            p_o     = pp;
            g_o     = gg;
            carry_o = cy_or;
            f1_o    = cy_or;
            f2_o    = sum;
         end
         FN_PARITY: begin
            p_o     = pp;
            g_o     = gg;
            carry_o = cy_alt;
            f1_o    = cy_alt;
            f2_o    = sum;
         end
         default: begin
            f1_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lcell_top.sv
module lcell_top
   import lcell_pkg::*;
#(
   parameter int unsigned NREG      = 9,
   parameter bit          XOR_CHAIN = 1'b1,
   localparam int unsigned RSEL_W   = (NREG > 1) ? $clog2(NREG + 1) : 1,
   localparam int unsigned OSEL_LSB = 0,
   localparam int unsigned RSEL_LSB = OSEL_LSB + N_ROUTE * SRC_W,
   localparam int unsigned ISEL_LSB = RSEL_LSB + N_PICK * RSEL_W,
   localparam int unsigned MODE_LSB = ISEL_LSB + N_FIN * SRC_W,
   localparam int unsigned TT_LSB   = MODE_LSB + MODE_W,
   localparam int unsigned CFG_W    = TT_LSB + TT_W
) (
   input  logic [CFG_W-1:0]   cfg_i,
   input  logic [NREG-1:0]    regs_i,
   input  logic [N_ROUTE-1:0] in_i,
   input  logic               carry_i,
   output logic [N_ROUTE-1:0] out_o,
   output logic               f1_o,
   output logic               f2_o,
   output logic               p_o,
   output logic               g_o,
   output logic               carry_o
);

   generate
      if (NREG < 2 || NREG > 15) begin : g_bad_nreg
         $error("lcell_top: NREG must lie in 2..15");
      end
   endgenerate

   fn_mode_e                  mode;
   logic [TT_W-1:0]           tt;
   logic [N_PICK-1:0]         pick;
   logic [N_FIN-1:0]          fin;
   logic [N_ROUTE*SRC_W-1:0]  osel_w;
   logic [N_SRC-1:0]          fin_src;
   logic [N_SRC-1:0]          out_src;

   assign mode   = fn_mode_e'(cfg_i[MODE_LSB +: MODE_W]);
   assign tt     = cfg_i[TT_LSB +: TT_W];
   assign osel_w = cfg_i[OSEL_LSB +: N_ROUTE*SRC_W];

   // register bit selection
   generate
      for (genvar k = 0; k < N_PICK; k++) begin : g_pick
         lcell_regpick #(
            .NREG  (NREG),
            .SEL_W (RSEL_W)
         ) u_pick (
            .regs_i (regs_i),
            .sel_i  (cfg_i[RSEL_LSB + k*RSEL_W +: RSEL_W]),
            .bit_o  (pick[k])
         );
      end
   endgenerate

   // function-block inputs
   assign fin_src = {1'b1, 1'b0, pick[1], pick[0], in_i};

   generate
      for (genvar k = 0; k < N_FIN; k++) begin : g_fin
         lcell_mux #(.SEL_W(SRC_W)) u_fin (
            .src_i (fin_src),
            .sel_i (cfg_i[ISEL_LSB + k*SRC_W +: SRC_W]),
            .y_o   (fin[k])
         );
      end
   endgenerate

   lcell_func #(.XOR_CHAIN(XOR_CHAIN)) u_func (
      .tt_i    (tt),
      .mode_i  (mode),
      .a_i     (fin[0]),
      .b_i     (fin[1]),
      .c_i     (fin[2]),
      .d_i     (fin[3]),
      .carry_i (carry_i),
      .f1_o    (f1_o),
      .f2_o    (f2_o),
      .p_o     (p_o),
      .g_o     (g_o),
      .carry_o (carry_o)
   );

   // routed outputs toward the next row
   assign out_src = {pick[1], pick[0], f2_o, f1_o, in_i};

   generate
      for (genvar k = 0; k < N_ROUTE; k++) begin : g_out
         lcell_mux #(.SEL_W(SRC_W)) u_out (
            .src_i (out_src),
            .sel_i (osel_w[k*SRC_W +: SRC_W]),
            .y_o   (out_o[k])
         );
      end
   endgenerate

endmodule

// File: rtl/lcell_chk.sv
module lcell_chk
   import lcell_pkg::*;
#(
   parameter bit XOR_CHAIN = 1'b1
) (
   input logic [MODE_W-1:0]        mode_i,
   input logic [N_ROUTE*SRC_W-1:0] osel_i,
   input logic [N_ROUTE-1:0]       in_i,
   input logic [N_ROUTE-1:0]       out_i,
   input logic                     f1_i,
   input logic                     f2_i,
   input logic                     carry_i,
   input logic                     p_i,
   input logic                     g_i,
   input logic                     carry_o_i
);

   logic chain_mode;
   assign chain_mode = (mode_i == FN_CARRY) || (mode_i == FN_PARITY);

   always_comb begin
      // R6
      carry_gen_chk: assert (!(mode_i == FN_CARRY && g_i) || carry_o_i)
         else $error("generate term did not raise carry");
      // R6
      carry_kill_chk: assert (!(chain_mode && !p_i && !g_i) || !carry_o_i)
         else $error("carry raised with neither propagate nor generate");
      // R7
      parity_chain_chk: assert (!(XOR_CHAIN && mode_i == FN_PARITY && p_i)
                                || (carry_o_i == (g_i ^ carry_i)))
         else $error("parity chain did not combine by exclusive-or");
      // R8
      lut_idle_chk: assert (chain_mode || (!carry_o_i && !p_i && !g_i))
         else $error("carry outputs active in a LUT mode");
      // R6
      carry_f1_chk: assert (!chain_mode || (f1_i == carry_o_i))
         else $error("f1 differs from chain output in a chain mode");
      for (int k = 0; k < N_ROUTE; k++) begin
         // R2
         route_chk: assert ((osel_i[k*SRC_W +: SRC_W] > 3'd3)
                            || (out_i[k] == in_i[osel_i[k*SRC_W +: 2]]))
            else $error("routed output does not follow selected input");
         // R2
         route_fn_chk: assert (!(osel_i[k*SRC_W +: SRC_W] == OUT_F2) || (out_i[k] == f2_i))
            else $error("routed output does not follow f2");
      end
   end

endmodule

bind lcell_top lcell_chk #(.XOR_CHAIN(XOR_CHAIN)) u_lcell_chk (
   .mode_i    (cfg_i[MODE_LSB +: MODE_W]),
   .osel_i    (osel_w),
   .in_i      (in_i),
   .out_i     (out_o),
   .f1_i      (f1_o),
   .f2_i      (f2_o),
   .carry_i   (carry_i),
   .p_i       (p_o),
   .g_i       (g_o),
   .carry_o_i (carry_o)
);

// File: tb/test_lcell_top.sv
module test_lcell_top;

   localparam int W = 32;

   logic clk = 1'b0;
   always #2ns clk = ~clk;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   // single cell under test
   logic [49:0] cfg;
   logic [8:0]  regs;
   logic [3:0]  ins;
   logic        cin;
   logic [3:0]  outs;
   logic        f1, f2, p, g, cout;

   lcell_top i_lcell_top (
      .cfg_i   (cfg),
      .regs_i  (regs),
      .in_i    (ins),
      .carry_i (cin),
      .out_o   (outs),
      .f1_o    (f1),
      .f2_o    (f2),
      .p_o     (p),
      .g_o     (g),
      .carry_o (cout)
   );

   // 32-cell row with chained carries
   logic [49:0]  c_cfg;
   logic [W-1:0] c_r0, c_r1;
   logic [W:0]   c_cy;
   logic [W-1:0] c_f1, c_f2, c_p, c_g;
   logic [3:0]   c_out [W];

   generate
      for (genvar k = 0; k < W; k++) begin : g_row
         lcell_top u_cell (
            .cfg_i   (c_cfg),
            .regs_i  ({7'b0, c_r1[k], c_r0[k]}),
            .in_i    (4'b0),
            .carry_i (c_cy[k]),
            .out_o   (c_out[k]),
            .f1_o    (c_f1[k]),
            .f2_o    (c_f2[k]),
            .p_o     (c_p[k]),
            .g_o     (c_g[k]),
            .carry_o (c_cy[k+1])
         );
      end
   endgenerate

   function automatic logic [49:0] mk_cfg(
      input logic [15:0] tt, input logic [1:0] mode,
      input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sc, input logic [2:0] sd,
      input logic [3:0] r0, input logic [3:0] r1,
      input logic [2:0] o1, input logic [2:0] o2, input logic [2:0] o3, input logic [2:0] o4);
      return {tt, mode, sd, sc, sb, sa, r1, r0, o4, o3, o2, o1};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_default();
      @(posedge clk);
      cfg = '0; regs = 9'h1A5; ins = 4'b1010; cin = 1'b1;
      settle();
      // all-zero configuration: every output follows I1, LUT4 with zero table
      chk("R2 default route", {60'b0, outs}, 64'h0);
      chk("R8 default carry idle", {61'b0, cout, p, g}, 64'h0);
      ins = 4'b0001;
      settle();
      chk("R2 default route I1", {60'b0, outs}, 64'hF);
   endtask

   task automatic t_regpick();
      regs = 9'b1_0110_1001;
      for (int k = 0; k < 16; k++) begin
         @(posedge clk);
         cfg = mk_cfg(16'h0, 2'd0, 0, 0, 0, 0, 4'(k), 4'(15 - k), 3'd6, 3'd7, 3'd6, 3'd7);
         settle();
         chk("R1 pick0", {63'b0, outs[0]}, {63'b0, (k < 9) ? regs[k] : 1'b0});
         chk("R1 pick1", {63'b0, outs[1]}, {63'b0, (15 - k < 9) ? regs[15 - k] : 1'b0});
      end
   endtask

   task automatic t_route();
      regs = 9'b0_0000_0010;
      for (int v = 0; v < 16; v++) begin
         @(posedge clk);
         ins = 4'(v);
         // table T=16'hFF00 so f1 = 1, f2 = d with a..d = I1..I4
         cfg = mk_cfg(16'hFF00, 2'd0, 0, 1, 2, 3, 4'd0, 4'd1, 3'd3, 3'd0, 3'd4, 3'd5);
         settle();
         chk("R2 O1<-I4", {63'b0, outs[0]}, {63'b0, ins[3]});
         chk("R2 O2<-I1", {63'b0, outs[1]}, {63'b0, ins[0]});
         chk("R2 O3<-F1", {63'b0, outs[2]}, 64'h1);
         chk("R2 O4<-F2", {63'b0, outs[3]}, {63'b0, ins[3]});
         cfg = mk_cfg(16'hFF00, 2'd0, 0, 1, 2, 3, 4'd0, 4'd1, 3'd6, 3'd7, 3'd2, 3'd1);
         settle();
         chk("R2 pick routes", {62'b0, outs[1:0]}, 64'h2);
         chk("R2 O3<-I3 O4<-I2", {62'b0, outs[3:2]}, {62'b0, ins[1], ins[2]});
      end
   endtask

   task automatic t_lut4();
      logic [15:0] tt;
      tt = 16'hB52E;
      for (int v = 0; v < 16; v++) begin
         @(posedge clk);
         ins = 4'(v);
         // a=I1 b=I2 c=I3 d=I4
         cfg = mk_cfg(tt, 2'd0, 0, 1, 2, 3, 4'd0, 4'd0, 3'd5, 3'd4, 3'd0, 3'd0);
         settle();
         chk("R4 f2", {63'b0, f2}, {63'b0, tt[v]});
         chk("R4 f1", {63'b0, f1}, {63'b0, tt[{1'b1, ins[2:0]}]});
      end
      // R3: inputs from picks and constants: a=1 b=pick0 c=0 d=pick1
      regs = 9'b0_0000_0110;
      @(posedge clk);
      cfg = mk_cfg(tt, 2'd0, 3'd7, 3'd4, 3'd6, 3'd5, 4'd1, 4'd2, 3'd5, 3'd0, 3'd0, 3'd0);
      settle();
      chk("R3 const/pick inputs", {63'b0, f2}, {63'b0, tt[4'b1011]});
      regs = 9'b0;
      settle();
      chk("R3 const/pick inputs zero regs", {63'b0, f2}, {63'b0, tt[4'b0001]});
   endtask

   task automatic t_split();
      logic [15:0] tt;
      tt = 16'h6A0F;
      for (int v = 0; v < 16; v++) begin
         @(posedge clk);
         ins = 4'(v);
         cfg = mk_cfg(tt, 2'd1, 0, 1, 2, 3, 4'd0, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0);
         settle();
         chk("R5 f1 left", {63'b0, f1}, {63'b0, tt[{1'b1, ins[2], ins[1], ins[0]}]});
         chk("R5 f2 right", {63'b0, f2}, {63'b0, tt[{1'b0, ins[3], ins[1], ins[0]}]});
         chk("R8 split idle", {61'b0, cout, p, g}, 64'h0);
      end
   endtask

   task automatic t_carry_cell(input logic [1:0] mode, input string req);
      logic [15:0] tt;
      logic        ep, eg, ec;
      tt = 16'hD4A7;
      for (int v = 0; v < 8; v++) begin
         @(posedge clk);
         ins = {2'b0, v[1], v[0]};
         cin = v[2];
         cfg = mk_cfg(tt, mode, 0, 1, 6, 6, 4'd0, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0);
         settle();
         ep = tt[{2'b10, ins[1], ins[0]}];
         eg = tt[{2'b11, ins[1], ins[0]}];
         ec = (mode == 2'd2) ? (eg | (ep & cin)) : (eg ^ (ep & cin));
         chk({req, " p/g"}, {62'b0, p, g}, {62'b0, ep, eg});
         chk({req, " carry"}, {63'b0, cout}, {63'b0, ec});
         chk({req, " f1"}, {63'b0, f1}, {63'b0, ec});
         chk({req, " sum"}, {63'b0, f2}, {63'b0, tt[{1'b0, cin, ins[1], ins[0]}]});
      end
   endtask

   task automatic t_row_arith(input logic [W-1:0] x, input logic [W-1:0] y, input bit sub);
      logic [W:0] exp;
      @(posedge clk);
      c_r0 = x; c_r1 = y;
      c_cfg = mk_cfg(sub ? 16'h2969 : 16'h8696, 2'd2, 3'd4, 3'd5, 3'd6, 3'd6,
                     4'd0, 4'd1, 3'd0, 3'd0, 3'd0, 3'd0);
      c_cy[0] = sub;
      settle();
      exp = sub ? ({1'b0, x} + {1'b0, ~y} + 33'd1) : ({1'b0, x} + {1'b0, y});
      chk(sub ? "R9 row difference" : "R9 row sum", {32'b0, c_f2}, {32'b0, exp[W-1:0]});
      chk(sub ? "R9 row borrow-out" : "R9 row carry-out", {63'b0, c_cy[W]}, {63'b0, exp[W]});
   endtask

   task automatic t_row_parity(input logic [W-1:0] x, input logic [W-1:0] y);
      @(posedge clk);
      c_r0 = x; c_r1 = y;
      // R7: p = 1, g = a ^ b
      c_cfg = mk_cfg({4'b0110, 4'b1111, 8'h00}, 2'd3, 3'd4, 3'd5, 3'd6, 3'd6,
                     4'd0, 4'd1, 3'd0, 3'd0, 3'd0, 3'd0);
      c_cy[0] = 1'b0;
      settle();
      chk("R7 row parity", {63'b0, c_cy[W]}, {63'b0, ^(x ^ y)});
      // R9: same in carry mode gives an or-reduction, not parity
      c_cfg = mk_cfg({4'b0110, 4'b1111, 8'h00}, 2'd2, 3'd4, 3'd5, 3'd6, 3'd6,
                     4'd0, 4'd1, 3'd0, 3'd0, 3'd0, 3'd0);
      settle();
      chk("R9 row or-reduce", {63'b0, c_cy[W]}, {63'b0, |(x ^ y)});
   endtask

   task automatic t_idle();
      for (int m = 0; m < 2; m++) begin
         @(posedge clk);
         cin = 1'b1; ins = 4'hF;
         cfg = mk_cfg(16'hFFFF, 2'(m), 0, 1, 2, 3, 4'd0, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0);
         settle();
         chk("R8 LUT mode carry idle", {61'b0, cout, p, g}, 64'h0);
      end
   endtask

   initial begin
      cfg = '0; regs = '0; ins = '0; cin = 1'b0;
      c_cfg = '0; c_r0 = '0; c_r1 = '0; c_cy[0] = 1'b0;
      t_default();
      t_regpick();
      t_route();
      t_lut4();
      t_split();
      t_idle();
      t_carry_cell(2'd2, "R6 cell");
      t_carry_cell(2'd3, "R7 cell");
      t_row_arith(32'h0000_1234, 32'h0000_4321, 1'b0);
      t_row_arith(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
      t_row_arith(32'h8000_0000, 32'h8000_0000, 1'b0);
      t_row_arith(32'h0000_0000, 32'h0000_0001, 1'b1);
      t_row_arith(32'h1234_5678, 32'h1234_5678, 1'b1);
      for (int i = 0; i < 20; i++) begin
         t_row_arith($urandom, $urandom, i[0]);
         t_row_parity($urandom, $urandom);
      end
      t_row_parity(32'h0000_0003, 32'h0);
      t_row_parity(32'h8000_0000, 32'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule